// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block turns the single-bit output of a delta-sigma modulator into multi-bit samples at a lower rate. It passes the bitstream through three cascaded integrators, which run at the modulator rate. It then passes the result through three comb stages, which run once per output word. The result is a sinc-cubed low-pass response. A programmable filter code sets the decimation ratio. The ratio fixes both the output word rate and the position of the first response notch. Changing the code slides the notches along the frequency axis and leaves the shape of the response as it is. Like any filter of this kind, the response has no rejection near integer multiples of the modulator sample rate.

The decimation ratio is `max(code, CODE_MIN) * R_UNIT` accepted modulator bits. With the defaults (an 11-bit code, a minimum of 10 and a unit of 512), a 10 MHz modulator clock gives output rates from about 1.95 kHz down to about 10 Hz. Both ends of that range scale linearly with the clock.

A step at the input, a restart or a new code needs three to four conversion periods to work through the filter. For that reason the data-valid strobe stays low for the first three words after any of these events. The internal accumulator is `1 + 3*ceil(log2(Rmax))` bits wide and uses wraparound arithmetic. The output word is the top `OUT_W` bits of that accumulator, so `OUT_W` must not exceed the accumulator width.

Top module: `sinc3_decim`

## Requirements
- R1: With bit value 1 counted as 1 and 0 counted as 0, each output word (before truncation) equals the sum of the last 3R accepted bits weighted by the kernel h[k], for k = 0 to 3R-3. The kernel h is three length-R boxcars convolved together. Bits accepted before the most recent clear count as 0.
- R2: The decimation ratio is R = max(code, CODE_MIN) * R_UNIT. An output event happens on every R-th accepted bit after a clear.
- R3: A code below CODE_MIN (10 by default) behaves exactly like CODE_MIN.
- R4: In a cycle where ce_i is low, bit_i is ignored and the filter does not advance: no output event occurs and result_o holds.
- R5: valid_o is high for exactly one cycle. That cycle follows the clock edge that accepts the bit completing a settled output. result_o changes only in cycles where valid_o is high.
- R6: After a reset or a clear, the first three output events leave valid_o low and result_o unchanged. The fourth and later events raise valid_o.
- R7: A restart_i pulse clears all filter state and the output-event count. The bit presented in that same cycle is discarded.
- R8: In any cycle where code_i differs from the code seen in the previous cycle, the block clears exactly as for R7, and the new code takes effect from then on.
- R9: result_o is the top OUT_W bits of the (1 + 3*ceil(log2(Rmax)))-bit filter value. An all-ones input therefore gives R^3 shifted right by (accumulator width - OUT_W).
- R10: While reset is asserted and right after it, result_o is 0 and valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Modulator bit enable |
| bit_i | input | 1 | Modulator bit |
| code_i | input | CODE_W | Filter code (decimation ratio in units of R_UNIT) |
| restart_i | input | 1 | Clear the filter and restart settling |
| result_o | output | OUT_W | Filtered, decimated word |
| valid_o | output | 1 | One-cycle strobe marking a new settled word |

## Verification
A corrupted integrator or comb delay does not show up at once. It appears in the first valid word after the fault: within one conversion period if a comb delay is hit, and in every later word if an integrator is hit. An off-by-one in the decimation counter moves the valid strobe away from the R-th accepted bit on the very next event. A wrong settling count either shows a valid strobe on the third word after a clear, or misses the one on the fourth. A clear that fails to discard the current bit, or misses a code change, shifts the weighted sum and is caught in the first valid word. The bench therefore sweeps every code of a small configuration, including the clamped ones. It compares every valid word to a direct kernel convolution, and checks the strobe timing on every cycle.

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int CODE_W   = 11,
  parameter int CODE_MIN = 10,
  parameter int R_UNIT   = 512,
  parameter int OUT_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              bit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              restart_i,
  output logic [OUT_W-1:0]  result_o,
  output logic              valid_o
);
  localparam int RMAX  = ((1 << CODE_W) - 1) * R_UNIT;
  localparam int RB    = $clog2(RMAX);
  localparam int ACC_W = 1 + 3 * RB;

  logic [CODE_W-1:0] code_q, eff;
  logic [RB:0]       cnt, last;
  logic [1:0]        settle;
  logic [ACC_W-1:0]  i1, i2, i3, d1, d2, d3;
  logic [ACC_W-1:0]  n1, n2, n3, c1, c2, c3;
  logic              clear, dump;

  assign eff   = (int'(code_q) < CODE_MIN) ? CODE_W'(CODE_MIN) : code_q;
  assign last  = (RB+1)'(int'(eff) * R_UNIT - 1);
  assign clear = restart_i | (code_i != code_q);
  assign dump  = ce_i & ~clear & (cnt == last);

  assign n1 = i1 + ACC_W'(bit_i);
  assign n2 = i2 + n1;
  assign n3 = i3 + n2;
  assign c1 = n3 - d1;
  assign c2 = c1 - d2;
  assign c3 = c2 - d3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      cnt      <= '0;
      settle   <= '0;
      i1       <= '0;
      i2       <= '0;
      i3       <= '0;
      d1       <= '0;
      d2       <= '0;
      d3       <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      code_q  <= code_i;
      valid_o <= 1'b0;
      if (clear) begin
        cnt    <= '0;
        settle <= '0;
        i1     <= '0;
        i2     <= '0;
        i3     <= '0;
        d1     <= '0;
        d2     <= '0;
        d3     <= '0;
      end else if (ce_i) begin
        i1 <= n1;
        i2 <= n2;
        i3 <= n3;
        if (dump) begin
          cnt <= '0;
          d1  <= n3;
          d2  <= c1;
          d3  <= c2;
          if (settle == 2'd3) begin
            result_o <= c3[ACC_W-1 -: OUT_W];
            valid_o  <= 1'b1;
          end else begin
            settle <= settle + 2'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int CODE_W   = 11,
  parameter int CODE_MIN = 10,
  parameter int R_UNIT   = 512,
  parameter int OUT_W    = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_i,
  input logic              restart_i,
  input logic [CODE_W-1:0] code_i,
  input logic [OUT_W-1:0]  result_o,
  input logic              valid_o
);
  localparam int MIN_GAP = CODE_MIN * R_UNIT;

  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (valid_o) begin
      gap  <= 32'd1;
      seen <= 1'b1;
    end else if (gap != 32'hFFFF_FFFF) begin
      gap <= gap + 32'd1;
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r5_result_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));
  a_r4_valid_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(ce_i));
  a_r7_restart_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !valid_o);
  a_r8_code_change_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i != $past(code_i)) |=> !valid_o);
  a_r2_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && seen) |-> (gap >= 32'(MIN_GAP)));
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .R_UNIT(R_UNIT), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .restart_i(restart_i),
  .code_i(code_i), .result_o(result_o), .valid_o(valid_o)
);

// File: tb/sinc3_decim_tb_top.sv
module sinc3_decim_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_i = 1'b0;
  logic        bit_i = 1'b0;
  logic        restart_i = 1'b0;
  logic [4:0]  code_i = 5'd0;
  logic [15:0] res_i;
  logic [11:0] res_t;
  logic        val_i, val_t;

  always #10 clk = ~clk;

  sinc3_decim #(.CODE_W(5), .CODE_MIN(10), .R_UNIT(1), .OUT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .bit_i(bit_i), .code_i(code_i),
    .restart_i(restart_i), .result_o(res_i), .valid_o(val_i));

  sinc3_decim #(.CODE_W(5), .CODE_MIN(10), .R_UNIT(1), .OUT_W(12)) dut_t (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .bit_i(bit_i), .code_i(code_i),
    .restart_i(restart_i), .result_o(res_t), .valid_o(val_t));

  int total = 0;
  int fails = 0;
  int ratio = 10;
  int nsamp = 0;
  int ndump = 0;
  int cur_code = 0;
  int prev_i = 0;
  int prev_t = 0;
  int h[0:127];
  bit hist[0:4095];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_kernel(input int r);
    for (int k = 0; k < 128; k++) h[k] = 0;
    for (int a = 0; a < r; a++)
      for (int b = 0; b < r; b++)
        for (int c = 0; c < r; c++) h[a+b+c]++;
  endtask

  function automatic int model_y();
    int y = 0;
    for (int k = 0; k <= 3*ratio - 3; k++) begin
      int idx = nsamp - 1 - k;
      if (idx >= 0 && hist[idx]) y += h[k];
    end
    return y;
  endfunction

  task automatic step(input bit ce, input bit b, input bit rs, input int code);
    bit clr;
    bit dmp;
    ce_i = ce; bit_i = b; restart_i = rs; code_i = code[4:0];
    @(negedge clk);
    clr = rs || (code != cur_code);
    cur_code = code;
    dmp = 1'b0;
    if (clr) begin
      nsamp = 0;
      ndump = 0;
      ratio = (code < 10) ? 10 : code;
      build_kernel(ratio);
    end else if (ce) begin
      hist[nsamp] = b;
      nsamp++;
      if (nsamp % ratio == 0) begin
        ndump++;
        dmp = 1'b1;
      end
    end
    if (clr) begin
      chk(rs ? "R7 valid after restart" : "R8 valid after code change", int'(val_i), 0);
      chk("R7/R8 result hold", int'(res_i), prev_i);
    end else if (!ce) begin
      chk("R4 valid with ce low", int'(val_i), 0);
      chk("R4 result hold with ce low", int'(res_i), prev_i);
    end else if (dmp && ndump >= 4) begin
      int y = model_y();
      chk((code < 10) ? "R3 clamped valid" : "R5 valid on settled event", int'(val_i), 1);
      chk((code < 10) ? "R3 clamped result" : "R1 result", int'(res_i), y);
      chk("R9 truncated result", int'(res_t), y >> 4);
      chk("R9 truncated valid", int'(val_t), 1);
      prev_i = y;
      prev_t = y >> 4;
    end else if (dmp) begin
      chk("R6 unsettled valid", int'(val_i), 0);
      chk("R6 unsettled result hold", int'(res_i), prev_i);
    end else begin
      chk("R2 no event between ratios", int'(val_i), 0);
      chk("R5 result hold", int'(res_i), prev_i);
    end
  endtask

  function automatic bit pat(input int mode, input int n);
    case (mode)
      0: return 1'b1;
      1: return n[0];
      2: return lfsr[0];
      default: return (n % 3) != 0;
    endcase
  endfunction

  task automatic run_events(input int mode, input int target, input int code);
    int n = 0;
    while (ndump < target) begin
      if (n % 4 == 3) step(1'b0, ~pat(mode, n), 1'b0, code);
      else step(1'b1, pat(mode, n), 1'b0, code);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      n++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(val_i), 0);
    chk("R10 reset result", int'(res_i), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", int'(val_i), 0);
    chk("R10 result after reset", int'(res_i), 0);

    for (int code = 0; code < 32; code++) begin
      step(1'b1, 1'b1, 1'b1, code);
      run_events(code % 4, 6, code);
    end

    // R9 full scale with the largest ratio
    step(1'b1, 1'b0, 1'b1, 31);
    run_events(0, 5, 31);
    chk("R9 full scale", int'(res_i), 31*31*31);
    chk("R9 full scale truncated", int'(res_t), (31*31*31) >> 4);

    // R8: code change mid-frame, with a settled stream running
    step(1'b1, 1'b1, 1'b1, 12);
    run_events(2, 5, 12);
    repeat (5) step(1'b1, 1'b1, 1'b0, 12);
    step(1'b1, 1'b1, 1'b0, 13);
    run_events(3, 6, 13);

    // R8: change between two codes that clamp to the same ratio
    step(1'b1, 1'b1, 1'b0, 3);
    run_events(1, 5, 3);
    step(1'b1, 1'b1, 1'b0, 5);
    run_events(2, 5, 5);

    // R7: restart mid-frame with an unchanged code
    repeat (4) step(1'b1, 1'b1, 1'b0, 5);
    step(1'b1, 1'b1, 1'b1, 5);
    run_events(0, 6, 5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule